// File: doc/BRIEF.md
# Sign-Split Reordering Accumulator

This block sums a stream of signed operands for one dot product at a time, and it changes the order of the additions while the stream arrives. The sign bit of each accepted operand decides which of two running sums it joins. One sum takes zero and positive values. The other takes negative values. Neither sum ever adds two operands of opposite sign. Operands of opposite sign meet only once per dot product, in a single combining addition after the operand flagged as last.

An upstream stage drives one operand per cycle with a valid flag and a last flag. There is no backpressure. Idle cycles may fall anywhere in a stream. A per-product mode bit, taken together with the last operand, selects how the combining addition reports its result. In full mode the result is the complete wide sum. In narrow mode only the low bits of the sum are kept and then sign-extended. This narrow mode suits products known to carry only small values. The two group totals are also brought out next to the result.

Top module: `sign_split_accum`

## Requirements
- R1: An accepted operand whose most significant bit is 1 changes only the negative group sum. An accepted operand whose most significant bit is 0, zero included, changes only the positive group sum.
- R2: Each group sum equals the sign-extended total of the operands routed to it since the start of the dot product, modulo 2^ACC_W. Both sums are visible on `out_pos_sum` and `out_neg_sum` after every accepted operand.
- R3: In full mode (`in_narrow`=0 with the last operand), `out_result` equals the in-order sum of all operands of the product modulo 2^ACC_W, with two's-complement wrap.
- R4: In narrow mode (`in_narrow`=1 with the last operand), `out_result` is the low RED_W bits of that sum, sign-extended from bit RED_W-1 to ACC_W bits.
- R5: `out_valid` is high for exactly the one cycle that follows the acceptance of an operand with `in_last`=1, and low in every other cycle.
- R6: The first operand accepted after a last operand, or after reset, starts a new product. Both group sums restart from zero, even when that operand arrives in the same cycle that `out_valid` is high.
- R7: While and just after `rst` is high, `out_valid` is 0 and both group sums are 0.
- R8: For the stream -1, 1, -1, 1 the positive sum is 2, the negative sum is -2 and the result is 0.
- R9: A cycle with `in_valid` low changes neither group sum.
- R10: A product made of a single operand, which carries the last flag itself, yields that operand sign-extended as its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | DATA_W | Signed operand, two's complement |
| in_last | input | 1 | Operand closes the current product |
| in_narrow | input | 1 | Narrow combining mode, taken with the last operand |
| out_valid | output | 1 | One-cycle result pulse |
| out_result | output | ACC_W | Combined result of the product |
| out_pos_sum | output | ACC_W | Non-negative group sum |
| out_neg_sum | output | ACC_W | Negative group sum |

## Verification
The bench builds the block with DATA_W=8, ACC_W=12 and RED_W=6. At these widths the complete operand range is small enough to sweep. Every single-operand product is tried in both modes, and a dense grid of operand pairs runs back to back so that each product starts in the cycle of the previous result. A 12-bit sum overflows after a few dozen full-scale operands, which brings wrap of both group sums and the 6-bit narrow sign extension within easy reach.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

    // Group index: the value equals the operand sign bit.
    typedef enum logic {
        GRP_POS = 1'b0,
        GRP_NEG = 1'b1
    } grp_e;

    localparam int NUM_GRP = 2;

    // Per-cycle control produced by the sequencer.
    typedef struct packed {
        logic start;   // next accepted operand opens a product
        logic fire;    // result pulse
        logic narrow;  // combining mode for the held result
    } seq_ctl_t;

    function automatic grp_e pick_group(input logic sign_bit);
        return sign_bit ? GRP_NEG : GRP_POS;
    endfunction

endpackage

// File: rtl/ssa_sequencer.sv
module ssa_sequencer
    import ssa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     in_last,
    input  logic     in_narrow,
    output seq_ctl_t ctl
);

    seq_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.start  <= 1'b1;
            ctl_q.fire   <= 1'b0;
            ctl_q.narrow <= 1'b0;
        end else begin
            ctl_q.fire <= in_valid & in_last;
            if (in_valid) begin
                ctl_q.start <= in_last;
                if (in_last) begin
                    ctl_q.narrow <= in_narrow;
                end
            end
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/ssa_group_bank.sv
module ssa_group_bank
    import ssa_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic                              start,
    input  grp_e                              sel,
    input  logic [ACC_W-1:0]                  opnd,
    output logic [NUM_GRP-1:0][ACC_W-1:0]     sums
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lane
        logic             take;
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W-1:0] base;

        assign take = (sel == grp_e'(g));
        // A new product discards the previous total in both lanes.
        assign base = start ? '0 : acc_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else if (in_valid) begin
                acc_q <= take ? (base + opnd) : base;
            end
        end

        assign sums[g] = acc_q;
    end

endmodule

// File: rtl/ssa_combiner.sv
module ssa_combiner #(
    parameter int ACC_W = 24,
    parameter int RED_W = 16
) (
    input  logic [ACC_W-1:0] pos_sum,
    input  logic [ACC_W-1:0] neg_sum,
    input  logic             narrow,
    output logic [ACC_W-1:0] result
);

    logic [ACC_W-1:0] full_sum;

    // The single opposite-sign addition of a product.
    assign full_sum = pos_sum + neg_sum;

    if (RED_W < ACC_W) begin : g_trunc
        localparam int PAD_W = ACC_W - RED_W;
        logic [ACC_W-1:0] short_sum;
        assign short_sum = {{PAD_W{full_sum[RED_W-1]}}, full_sum[RED_W-1:0]};
        assign result = narrow ? short_sum : full_sum;
    end else begin : g_pass
        logic unused_mode;
        assign unused_mode = narrow;
        assign result = full_sum;
    end

endmodule

// File: rtl/sign_split_accum.sv
module sign_split_accum
    import ssa_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24,
    parameter int RED_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_narrow,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_result,
    output logic [ACC_W-1:0]  out_pos_sum,
    output logic [ACC_W-1:0]  out_neg_sum
);

    localparam int EXT_W = ACC_W - DATA_W;

    seq_ctl_t                      ctl;
    logic                          start_q;
    logic [ACC_W-1:0]              opnd_ext;
    grp_e                          grp_sel;
    logic [NUM_GRP-1:0][ACC_W-1:0] grp_sums;

    assign opnd_ext = {{EXT_W{in_data[DATA_W-1]}}, in_data};
    assign grp_sel  = pick_group(in_data[DATA_W-1]);

    ssa_sequencer seq_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_narrow (in_narrow),
        .ctl       (ctl)
    );

    assign start_q = ctl.start;

    ssa_group_bank #(.ACC_W(ACC_W)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .start    (start_q),
        .sel      (grp_sel),
        .opnd     (opnd_ext),
        .sums     (grp_sums)
    );

    ssa_combiner #(.ACC_W(ACC_W), .RED_W(RED_W)) comb_i (
        .pos_sum (grp_sums[GRP_POS]),
        .neg_sum (grp_sums[GRP_NEG]),
        .narrow  (ctl.narrow),
        .result  (out_result)
    );

    assign out_valid   = ctl.fire;
    assign out_pos_sum = grp_sums[GRP_POS];
    assign out_neg_sum = grp_sums[GRP_NEG];

endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_last,
    input logic              start_q,
    input logic              out_valid,
    input logic [ACC_W-1:0]  out_pos_sum,
    input logic [ACC_W-1:0]  out_neg_sum
);

    a_r5_pulse_after_last: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> out_valid);

    a_r5_no_stray_pulse: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> !out_valid);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_pos_sum) && $stable(out_neg_sum)));

    a_r1_nonneg_route: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !start_q && !in_data[DATA_W-1]) |=> $stable(out_neg_sum));

    a_r1_neg_route: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !start_q && in_data[DATA_W-1]) |=> $stable(out_pos_sum));

    a_r6_fresh_neg: assert property (@(posedge clk) disable iff (rst)
        (in_valid && start_q && !in_data[DATA_W-1]) |=> (out_neg_sum == '0));

    a_r6_fresh_pos: assert property (@(posedge clk) disable iff (rst)
        (in_valid && start_q && in_data[DATA_W-1]) |=> (out_pos_sum == '0));

    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pos_sum == '0 && out_neg_sum == '0));

endmodule

bind sign_split_accum ssa_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .start_q     (start_q),
    .out_valid   (out_valid),
    .out_pos_sum (out_pos_sum),
    .out_neg_sum (out_neg_sum)
);

// File: tb/sign_split_accum_tb.sv
module sign_split_accum_tb_top;

    localparam int DATA_W = 8;
    localparam int ACC_W  = 12;
    localparam int RED_W  = 6;
    localparam int MASK   = (1 << ACC_W) - 1;
    localparam int LOWM   = (1 << RED_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              in_narrow = 1'b0;
    logic              out_valid;
    logic [ACC_W-1:0]  out_result;
    logic [ACC_W-1:0]  out_pos_sum;
    logic [ACC_W-1:0]  out_neg_sum;

    int  n_checks = 0;
    int  n_errors = 0;
    int  pos_exp = 0;
    int  neg_exp = 0;
    int  sum_exp = 0;
    bit  fresh = 1'b1;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    sign_split_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .RED_W(RED_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .in_narrow   (in_narrow),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_pos_sum (out_pos_sum),
        .out_neg_sum (out_neg_sum)
    );

    function automatic int wrap(input int s);
        return s & MASK;
    endfunction

    function automatic int shorten(input int s);
        int lo;
        lo = s & LOWM;
        if (((lo >> (RED_W - 1)) & 1) == 1) lo = lo | (MASK & ~LOWM);
        return lo;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic drive_op(input int v, input bit last, input bit nar);
        in_valid  = 1'b1;
        in_data   = DATA_W'(v);
        in_last   = last;
        in_narrow = nar;
        if (fresh) begin
            pos_exp = 0;
            neg_exp = 0;
            sum_exp = 0;
            fresh   = 1'b0;
        end
        if (v < 0) neg_exp += v;
        else       pos_exp += v;
        sum_exp += v;
        @(posedge clk);
        @(negedge clk);
        chk("R1/R2 pos group", int'(out_pos_sum), wrap(pos_exp));
        chk("R1/R2 neg group", int'(out_neg_sum), wrap(neg_exp));
        chk("R5 valid timing", int'(out_valid), int'(last));
        if (last) begin
            if (nar) chk("R4 narrow result", int'(out_result), shorten(wrap(sum_exp)));
            else     chk("R3 full result", int'(out_result), wrap(sum_exp));
            fresh = 1'b1;
        end
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = DATA_W'(8'h81);
        @(posedge clk);
        @(negedge clk);
        chk("R9 idle pos hold", int'(out_pos_sum), wrap(pos_exp));
        chk("R9 idle neg hold", int'(out_neg_sum), wrap(neg_exp));
        chk("R5 idle no pulse", int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7: state straight out of reset
        chk("R7 reset valid", int'(out_valid), 0);
        chk("R7 reset pos", int'(out_pos_sum), 0);
        chk("R7 reset neg", int'(out_neg_sum), 0);
        idle();

        // R8: the four-operand example
        drive_op(-1, 0, 0);
        drive_op(1, 0, 0);
        drive_op(-1, 0, 0);
        drive_op(1, 1, 0);
        chk("R8 pos total", int'(out_pos_sum), 2);
        chk("R8 neg total", int'(out_neg_sum), wrap(-2));
        chk("R8 result", int'(out_result), 0);
        idle();

        // R10: every single-operand product, both modes
        for (int v = -128; v < 128; v++) begin
            drive_op(v, 1, 1'(v & 1));
            chk("R10 single", int'(out_result),
                (v & 1) ? shorten(wrap(v)) : wrap(v));
        end
        idle();

        // R6: back-to-back pairs over a dense grid
        for (int a = -128; a < 128; a++) begin
            for (int b = -128; b < 128; b += 17) begin
                drive_op(a, 0, 0);
                drive_op(b, 1, 1'((a ^ b) & 1));
            end
        end
        idle();

        // R9: idle cycles inside a product
        drive_op(5, 0, 0);
        idle();
        drive_op(-7, 0, 0);
        idle();
        idle();
        drive_op(0, 0, 0);
        drive_op(-1, 1, 0);
        idle();

        // R3/R4: wrap of both groups
        for (int mode = 0; mode < 2; mode++) begin
            for (int i = 0; i < 40; i++) drive_op(127, 0, 1'(mode));
            for (int i = 0; i < 39; i++) drive_op(-128, 0, 1'(mode));
            drive_op(-3, 1, 1'(mode));
            idle();
        end
        for (int i = 0; i < 50; i++) drive_op((i % 2) ? -100 : 90, i == 49, 1'b1);
        idle();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule